// File: doc/BRIEF.md
# Multi-View GPIO Port Register File

This block holds the output state of one general-purpose I/O port of up to 32 pins and lets software reach that single output latch through several register views: a byte-wide register and a word-wide register for each pin, a register for the whole port, a masked view of the port paired with its own mask register, and write-one set, clear and invert registers. A direction register picks which pins actually drive the pad. Reads of the pin-oriented views return the level seen on the pad input, not the latch.

The block sits on a simple synchronous register bus with an address, a write strobe, write data and combinational read data. Writes are captured on the rising clock edge at which the strobe is high. Reads follow the current address and state within the same cycle. The pad side is a plain input vector, a data vector and an enable vector. The address map is word-indexed. Address bits [7:6] select a region and bits [5:0] select an entry within it. Region 0 holds the per-pin byte registers at index = pin. Region 1 holds the per-pin word registers at index = pin. Region 2 holds the control registers at these indices: 0 direction, 1 mask, 2 port, 3 masked port, 4 set, 5 clear, 6 invert. Region 3 and every other index are unmapped.

Top module: `gpv_port`

## Requirements
- R1: After reset the direction, mask and output latch are all zero, so pad_oe and pad_out are 0 and reading the direction, mask and set registers (addresses 0x80, 0x81, 0x84) returns 0.
- R2: A write to byte register 0x00+p loads output bit p from write data bit 0. Other bits of the written word are ignored and other pins keep their value.
- R3: A write to word register 0x40+p loads output bit p with 1 when any of the 32 written bits is 1, and with 0 when the word is zero. Other pins keep their value.
- R4: A write to the port register 0x82 loads every output bit from the written word.
- R5: The mask register 0x81 reads back its last written value. A write to the masked port register 0x83 loads only the output bits whose mask bit is 0, and bits with mask bit 1 keep their value.
- R6: A read of the masked port register returns pad_in with every bit whose mask bit is 1 forced to 0. With a zero mask it reads and writes exactly like the port register.
- R7: Ones written to set (0x84), clear (0x85) or invert (0x86) set, clear or invert the matching output bits. Zero bits leave the output unchanged, and the mask has no effect on these three registers.
- R8: A read of the set register returns the current output latch.
- R9: A read of byte register p returns pad_in[p] in bit 0 and zeros above it. A read of word register p returns all ones when pad_in[p] is 1 and all zeros otherwise. A read of the port register returns pad_in, whatever the direction.
- R10: The direction register 0x80 reads back its value and drives pad_oe. pad_out carries the latch on pins with direction 1 and 0 on the others, and the latch updates on writes whatever the direction.
- R11: Writes take effect at the clock edge where bus_we is high. A cycle without bus_we, or a write to an unmapped address, changes nothing. Reads of unmapped addresses and of the clear and invert registers return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Word index of the register accessed |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | 32 | Level seen at each pin |
| pad_out | output | 32 | Output value, zero on pins not driven |
| pad_oe | output | 32 | Output enable per pin, from the direction register |

## Verification
A corrupted latch bit shows up on pad_out in the cycle after the faulty write, but only while that pin's direction bit is 1. For that reason the bench keeps many pins driven and also compares the set register read, which exposes the latch whatever the direction. A wrong mask value has no effect on port, set, clear or invert writes. It appears only through a masked-port write or read, so masked reads and writes are mixed into the random traffic. Port, set, clear, invert, masked, byte and word writes are interleaved so that a decode slip between views changes the latch within one cycle, and every clock is compared against the reference model.

// File: rtl/gpv_pkg.sv
package gpv_pkg;

    localparam int unsigned IDX_W = 6;
    localparam int unsigned REG_AW = IDX_W + 2;

    typedef enum logic [1:0] {
        RG_BYTE = 2'd0,
        RG_WORD = 2'd1,
        RG_CTL  = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    typedef enum logic [IDX_W-1:0] {
        CI_DIR   = 6'd0,
        CI_MASK  = 6'd1,
        CI_PORT  = 6'd2,
        CI_MPORT = 6'd3,
        CI_SET   = 6'd4,
        CI_CLR   = 6'd5,
        CI_TGL   = 6'd6
    } ctl_idx_e;

    typedef struct packed {
        logic             byte_hit;
        logic             word_hit;
        logic [IDX_W-1:0] idx;
        logic             dir;
        logic             mask;
        logic             port;
        logic             mport;
        logic             set;
        logic             clr;
        logic             tgl;
    } acc_t;

endpackage

// File: rtl/gpv_decode.sv
module gpv_decode
    import gpv_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input  logic [REG_AW-1:0] addr,
    output acc_t              acc
);

    region_e          region;
    logic [IDX_W-1:0] idx;
    logic             pin_ok;

    always_comb begin
        region = region_e'(addr[REG_AW-1:IDX_W]);
        idx    = addr[IDX_W-1:0];
        pin_ok = (int'(idx) < int'(NPIN));

        acc          = '0;
        acc.idx      = idx;
        acc.byte_hit = (region == RG_BYTE) && pin_ok;
        acc.word_hit = (region == RG_WORD) && pin_ok;
        if (region == RG_CTL) begin
            acc.dir   = (idx == CI_DIR);
            acc.mask  = (idx == CI_MASK);
            acc.port  = (idx == CI_PORT);
            acc.mport = (idx == CI_MPORT);
            acc.set   = (idx == CI_SET);
            acc.clr   = (idx == CI_CLR);
            acc.tgl   = (idx == CI_TGL);
        end
    end

endmodule

// File: rtl/gpv_latch.sv
module gpv_latch
    import gpv_pkg::*;
#(
    parameter int unsigned NPIN = 32,
    parameter int unsigned DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  acc_t            acc,
    input  logic [DW-1:0]   wdata,
    output logic [NPIN-1:0] lat_q,
    output logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] mask_q
);

    typedef struct packed {
        logic [NPIN-1:0] lat;
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] mask;
    } state_t;

    state_t          st_d, st_q;
    logic [NPIN-1:0] wvec;
    logic            word_true;

    always_comb begin
        wvec      = wdata[NPIN-1:0];
        word_true = |wdata;
        st_d      = st_q;
        if (we) begin
            for (int p = 0; p < int'(NPIN); p++) begin
                if (acc.idx == IDX_W'(p)) begin
                    if (acc.byte_hit) st_d.lat[p] = wdata[0];
                    if (acc.word_hit) st_d.lat[p] = word_true;
                end
            end
            if (acc.dir)   st_d.dir  = wvec;
            if (acc.mask)  st_d.mask = wvec;
            if (acc.port)  st_d.lat  = wvec;
            if (acc.mport) st_d.lat  = (st_q.lat & st_q.mask) | (wvec & ~st_q.mask);
            if (acc.set)   st_d.lat  = st_q.lat | wvec;
            if (acc.clr)   st_d.lat  = st_q.lat & ~wvec;
            if (acc.tgl)   st_d.lat  = st_q.lat ^ wvec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat_q  = st_q.lat;
    assign dir_q  = st_q.dir;
    assign mask_q = st_q.mask;

endmodule

// File: rtl/gpv_readmux.sv
module gpv_readmux
    import gpv_pkg::*;
#(
    parameter int unsigned NPIN = 32,
    parameter int unsigned DW   = 32
) (
    input  acc_t            acc,
    input  logic [NPIN-1:0] pad_in,
    input  logic [NPIN-1:0] lat,
    input  logic [NPIN-1:0] dir,
    input  logic [NPIN-1:0] mask,
    output logic [DW-1:0]   rdata
);

    logic pin_lvl;

    always_comb begin
        pin_lvl = 1'b0;
        for (int p = 0; p < int'(NPIN); p++) begin
            if (acc.idx == IDX_W'(p)) pin_lvl = pad_in[p];
        end

        rdata = '0;
        if (acc.byte_hit)   rdata[0] = pin_lvl;
        if (acc.word_hit)   rdata    = {DW{pin_lvl}};
        if (acc.dir)        rdata[NPIN-1:0] = dir;
        if (acc.mask)       rdata[NPIN-1:0] = mask;
        if (acc.port)       rdata[NPIN-1:0] = pad_in;
        if (acc.mport)      rdata[NPIN-1:0] = pad_in & ~mask;
        if (acc.set)        rdata[NPIN-1:0] = lat;
    end

endmodule

// File: rtl/gpv_port.sv
module gpv_port
    import gpv_pkg::*;
#(
    parameter int unsigned NPIN = 32,
    parameter int unsigned DW   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe
);

    acc_t            acc;
    logic [NPIN-1:0] lat_q, dir_q, mask_q;

    gpv_decode #(.NPIN(NPIN)) u_dec (
        .addr (bus_addr),
        .acc  (acc)
    );

    gpv_latch #(.NPIN(NPIN), .DW(DW)) u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .acc    (acc),
        .wdata  (bus_wdata),
        .lat_q  (lat_q),
        .dir_q  (dir_q),
        .mask_q (mask_q)
    );

    gpv_readmux #(.NPIN(NPIN), .DW(DW)) u_rd (
        .acc    (acc),
        .pad_in (pad_in),
        .lat    (lat_q),
        .dir    (dir_q),
        .mask   (mask_q),
        .rdata  (bus_rdata)
    );

    assign pad_oe  = dir_q;
    assign pad_out = lat_q & dir_q;

    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && acc.dir |=> pad_oe == $past(bus_wdata[NPIN-1:0])); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(lat_q) && $stable(dir_q) && $stable(mask_q)); // R11

    AST_MPORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && acc.mport |=> ((lat_q ^ $past(lat_q)) & $past(mask_q)) == '0); // R5

    AST_MPORT_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        acc.mport |-> (bus_rdata[NPIN-1:0] & mask_q) == '0); // R6

    AST_SET_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && acc.set |=> ($past(lat_q) & ~lat_q) == '0); // R7

endmodule

// File: tb/gpv_port_bench.sv
module gpv_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_lat = '0;
    logic [31:0] m_dir = '0;
    logic [31:0] m_mask = '0;
    logic [31:0] lf = 32'h1ACE_B00C;

    always #5 clk = ~clk;

    gpv_port u_gpv_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    // expected read value, from the requirements
    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        int i = int'(a[5:0]);
        case (a[7:6])
            2'd0: return (i < 32) ? {31'b0, pad_in[i]} : 32'h0;          // R9
            2'd1: return (i < 32) ? {32{pad_in[i]}} : 32'h0;             // R9
            2'd2: case (i)
                0: return m_dir;                                        // R10
                1: return m_mask;                                       // R5
                2: return pad_in;                                       // R9
                3: return pad_in & ~m_mask;                             // R6
                4: return m_lat;                                        // R8
                default: return 32'h0;                                  // R11
            endcase
            default: return 32'h0;                                      // R11
        endcase
    endfunction

    // model update applied after the capturing edge
    task automatic model_wr(input logic [7:0] a, input logic [31:0] d);
        int i = int'(a[5:0]);
        case (a[7:6])
            2'd0: if (i < 32) m_lat[i] = d[0];                          // R2
            2'd1: if (i < 32) m_lat[i] = (d != 0);                      // R3
            2'd2: case (i)
                0: m_dir = d;
                1: m_mask = d;
                2: m_lat = d;                                           // R4
                3: for (int b = 0; b < 32; b++) if (!m_mask[b]) m_lat[b] = d[b]; // R5
                4: m_lat = m_lat | d;                                   // R7
                5: m_lat = m_lat & ~d;                                  // R7
                6: m_lat = m_lat ^ d;                                   // R7
                default: ;
            endcase
            default: ;
        endcase
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1;
        model_wr(a, d);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp_rd(a));
    endtask

    // every-clock comparison of the pad side (R10)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 pad_oe", pad_oe, m_dir);
            chk("R10 pad_out", pad_out, m_lat & m_dir);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        #1;
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 pad_out", pad_out, 32'h0);
        rd("R1 dir", 8'h80);
        rd("R1 mask", 8'h81);
        rd("R1 set", 8'h84);

        wr(8'h80, 32'hFFFF_FFFF);                 // drive all pins
        // R2 byte: bit 0 only
        wr(8'h05, 32'hFFFF_FFFE); rd("R2 byte zero", 8'h84);
        wr(8'h05, 32'h0000_0003); rd("R2 byte one", 8'h84);
        wr(8'h1F, 32'h0000_0001); rd("R2 byte top", 8'h84);
        // R3 word: OR of all bits
        wr(8'h47, 32'h8000_0000); rd("R3 word msb", 8'h84);
        wr(8'h47, 32'h0000_0000); rd("R3 word zero", 8'h84);
        wr(8'h40, 32'h0001_0000); rd("R3 word mid", 8'h84);
        // R4 port
        wr(8'h82, 32'hA5A5_3C3C); rd("R4 port", 8'h84);
        // R5 masked write
        wr(8'h81, 32'hFFFF_0000); rd("R5 mask rb", 8'h81);
        wr(8'h83, 32'h1234_5678); rd("R5 mport", 8'h84);
        // R7 set/clr/not ignore mask
        wr(8'h84, 32'h0F00_000F); rd("R7 set", 8'h84);
        wr(8'h85, 32'hF000_00F0); rd("R7 clr", 8'h84);
        wr(8'h86, 32'hFFFF_0001); rd("R7 not", 8'h84);
        // R6 masked read
        pad_in = 32'hDEAD_BEEF;
        rd("R6 mport read", 8'h83);
        rd("R9 port read", 8'h82);
        rd("R9 byte read", 8'h00);
        rd("R9 word read", 8'h44);
        rd("R9 word read low", 8'h58);
        wr(8'h81, 32'h0);
        rd("R6 mask0 read", 8'h83);
        wr(8'h83, 32'hCAFE_F00D); rd("R6 mask0 write", 8'h84);
        // R10 direction partial, latch still updates
        wr(8'h80, 32'h0000_FFFF);
        wr(8'h82, 32'h7777_8888); rd("R10 latch undriven", 8'h84);
        // R11 unmapped / idle
        wr(8'h87, 32'hFFFF_FFFF); rd("R11 unmapped write", 8'h84);
        wr(8'h20, 32'hFFFF_FFFF); rd("R11 pin out of range", 8'h84);
        wr(8'hC3, 32'hFFFF_FFFF); rd("R11 region3", 8'h84);
        rd("R11 clr read", 8'h85);
        rd("R11 tgl read", 8'h86);
        rd("R11 unmapped read", 8'hC0);
        @(negedge clk); bus_addr = 8'h82; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk); rd("R11 no strobe", 8'h84);

        // mixed traffic
        for (int k = 0; k < 600; k++) begin
            logic [7:0]  a;
            logic [31:0] d;
            lf = step(lf); d = lf;
            lf = step(lf);
            case (lf[2:0])
                3'd0: a = {2'd0, 1'b0, lf[7:3]};
                3'd1: begin a = {2'd1, 1'b0, lf[7:3]}; if (lf[9:8] == 0) d = 0; end
                3'd2: a = 8'h80 + {5'd0, lf[5:3] % 3'd7};
                3'd3: a = 8'h83;
                3'd4: a = 8'h81;
                3'd5: a = 8'h84 + {6'd0, lf[4:3] % 2'd3};
                3'd6: a = lf[7:0];
                default: a = 8'h82;
            endcase
            pad_in = step(lf ^ 32'h5A5A_0F0F);
            if (lf[12]) wr(a, d);
            rd("R8 random", lf[13] ? 8'h84 : a);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule